// File: doc/BRIEF.md
# Interrupt Pin Request Tracker

This block watches a bank of interrupt input pins and decides, one pin at a time, which of them should be handed to the delivery logic. Each pin has a configuration entry that supplies a polarity, a trigger mode, a mask and a vector number. From the raw pin level and the polarity the block forms an effective request level. It then keeps a per-pin pending bit and, for level-triggered pins, an in-service flag that blocks further requests until the interrupt is acknowledged.

Edge-triggered pins latch a request when their effective level rises while unmasked. The request is held until the delivery logic accepts it. Level-triggered pins request for as long as their effective level is high and their in-service flag is clear. An accepted delivery on a level pin sets the flag. The flag clears when an end-of-interrupt message arrives that carries the pin's vector. Several pins may share one vector, and the message then releases all of them at once. When several pins want service, the lowest-numbered one is presented first, and each valid/ready handshake consumes exactly one request. Resolving which processor receives the interrupt is left to logic downstream.

Top module: `irq_tracker`

## Requirements
- R1: The effective level of pin i is pinLevel[i] XOR cfgPolarity[i]. With cfgPolarity[i]=1 the pin is active low. An effective level of 0 never creates a request.
- R2: A level pin (cfgLevelTrig[i]=1) requests service in the cycle after its effective level is sampled high, provided it is unmasked and its in-service flag is clear. The request is withdrawn in the cycle after the effective level is sampled low.
- R3: A handshake (svcValid=1 and svcReady=1 at a clock edge) on a level pin sets that pin's in-service flag. From the next cycle on, that pin does not request again while the flag stays set, even if its level stays high.
- R4: An end-of-interrupt strobe (eoiValid=1) clears the in-service flag of every level pin whose cfgVector field equals eoiVector. Pins with other vectors are unaffected. A released pin that is still high and unmasked requests again in the next cycle.
- R5: If a handshake on a level pin and a matching end-of-interrupt strobe happen in the same cycle, the handshake wins and the in-service flag stays set.
- R6: An edge pin (cfgLevelTrig[i]=0) latches a request on a rising effective level seen while unmasked. The request is held, even after the level falls, until a handshake clears it. A steady high level does not request again.
- R7: A masked pin (cfgMask[i]=1) is never presented on svcValid. A level pin's pending state keeps following its level while masked, so clearing the mask presents it in the same cycle. A rising edge seen on a masked edge pin is discarded. A request already latched on an edge pin is held across masking.
- R8: svcPin names the lowest-numbered requesting pin. svcVector and svcLevelTrig carry that pin's vector field (bits [i*VecW +: VecW] of cfgVector) and trigger mode. While svcValid=0, svcPin is 0.
- R9: While rstN is low, all pending and in-service state is cleared and svcValid is 0, whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinLevel | input | NumPins | Raw interrupt pin levels |
| cfgPolarity | input | NumPins | Per-pin polarity, 1 = active low |
| cfgLevelTrig | input | NumPins | Per-pin trigger mode, 1 = level, 0 = edge |
| cfgMask | input | NumPins | Per-pin mask, 1 = masked |
| cfgVector | input | NumPins*VecW | Per-pin vector fields, pin i at bits [i*VecW +: VecW] |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiVector | input | VecW | Vector carried by the end-of-interrupt strobe |
| svcReady | input | 1 | Delivery logic accepts the presented request |
| svcValid | output | 1 | A pin is requesting service |
| svcPin | output | PinIdxW | Index of the presented pin |
| svcVector | output | VecW | Vector of the presented pin |
| svcLevelTrig | output | 1 | Trigger mode of the presented pin |

## Verification
The bench builds the tracker with four pins and three-bit vectors. This makes it possible to sweep every pin through every combination of polarity and trigger mode, with the full request, accept and acknowledge sequence run for each one. The narrow vector field also makes shared vectors and non-matching acknowledge values easy to set up. These cover the multi-pin release of R4 and the same-cycle accept-and-acknowledge collision of R5. With so few pins, the priority order and the handover from one granted pin to the next can be checked exactly.

// File: rtl/irq_tracker_pkg.sv
package irq_tracker_pkg;

  // Per-pin strobes sent from the control module to the datapath.
  typedef struct packed {
    logic grant;     // handshake completed on this pin this cycle
    logic eoiClear;  // end-of-interrupt matched this level pin
  } pinStrobe_t;

endpackage

// File: rtl/irq_tracker_datapath.sv
module irq_tracker_datapath
  import irq_tracker_pkg::*;
#(
  parameter int NumPins = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NumPins-1:0] pinLevel,
  input  logic [NumPins-1:0] cfgPolarity,
  input  logic [NumPins-1:0] cfgLevelTrig,
  input  logic [NumPins-1:0] cfgMask,
  input  pinStrobe_t         strobe [NumPins],
  output logic [NumPins-1:0] reqVec
);

  for (genvar i = 0; i < NumPins; i++) begin : gPin
    logic effLevel;
    logic prevLevelQ;
    logic pendingQ;
    logic inServiceQ;
    logic riseSeen;

    assign effLevel = pinLevel[i] ^ cfgPolarity[i];
    assign riseSeen = effLevel & ~prevLevelQ & ~cfgMask[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevLevelQ <= 1'b0;
        pendingQ   <= 1'b0;
        inServiceQ <= 1'b0;
      end else begin
        prevLevelQ <= effLevel;
        if (cfgLevelTrig[i]) begin
          pendingQ <= effLevel;
        end else begin
          pendingQ <= riseSeen | (pendingQ & ~strobe[i].grant);
        end
        if (strobe[i].grant && cfgLevelTrig[i]) begin
          inServiceQ <= 1'b1;
        end else if (strobe[i].eoiClear) begin
          inServiceQ <= 1'b0;
        end
      end
    end

    assign reqVec[i] = pendingQ & ~cfgMask[i] & ~(cfgLevelTrig[i] & inServiceQ);
  end

endmodule

// File: rtl/irq_tracker_ctrl.sv
module irq_tracker_ctrl
  import irq_tracker_pkg::*;
#(
  parameter int NumPins = 24,
  parameter int VecW    = 8,
  localparam int PinIdxW = (NumPins > 1) ? $clog2(NumPins) : 1
) (
  input  logic [NumPins-1:0]      reqVec,
  input  logic [NumPins-1:0]      cfgLevelTrig,
  input  logic [NumPins*VecW-1:0] cfgVector,
  input  logic                    eoiValid,
  input  logic [VecW-1:0]         eoiVector,
  input  logic                    svcReady,
  output pinStrobe_t              strobe [NumPins],
  output logic                    svcValid,
  output logic [PinIdxW-1:0]      svcPin,
  output logic [VecW-1:0]         svcVector,
  output logic                    svcLevelTrig
);

  logic [PinIdxW-1:0] pick;

  // Lowest-numbered request wins: scan downward so the last hit is lowest.
  always_comb begin
    pick = '0;
    for (int i = NumPins - 1; i >= 0; i--) begin
      if (reqVec[i]) pick = PinIdxW'(i);
    end
  end

  assign svcValid     = |reqVec;
  assign svcPin       = pick;
  assign svcVector    = cfgVector[pick*VecW +: VecW];
  assign svcLevelTrig = cfgLevelTrig[pick];

  for (genvar i = 0; i < NumPins; i++) begin : gStrobe
    assign strobe[i].grant    = svcValid & svcReady & (pick == PinIdxW'(i));
    assign strobe[i].eoiClear = eoiValid & cfgLevelTrig[i] &
                                (cfgVector[i*VecW +: VecW] == eoiVector);
  end

endmodule

// File: rtl/irq_tracker.sv
module irq_tracker
  import irq_tracker_pkg::*;
#(
  parameter int NumPins = 24,
  parameter int VecW    = 8,
  localparam int PinIdxW = (NumPins > 1) ? $clog2(NumPins) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NumPins-1:0]      pinLevel,
  input  logic [NumPins-1:0]      cfgPolarity,
  input  logic [NumPins-1:0]      cfgLevelTrig,
  input  logic [NumPins-1:0]      cfgMask,
  input  logic [NumPins*VecW-1:0] cfgVector,
  input  logic                    eoiValid,
  input  logic [VecW-1:0]         eoiVector,
  input  logic                    svcReady,
  output logic                    svcValid,
  output logic [PinIdxW-1:0]      svcPin,
  output logic [VecW-1:0]         svcVector,
  output logic                    svcLevelTrig
);

  pinStrobe_t         strobe [NumPins];
  logic [NumPins-1:0] reqVec;

  irq_tracker_datapath #(.NumPins(NumPins)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .pinLevel     (pinLevel),
    .cfgPolarity  (cfgPolarity),
    .cfgLevelTrig (cfgLevelTrig),
    .cfgMask      (cfgMask),
    .strobe       (strobe),
    .reqVec       (reqVec)
  );

  irq_tracker_ctrl #(.NumPins(NumPins), .VecW(VecW)) u_ctrl (
    .reqVec       (reqVec),
    .cfgLevelTrig (cfgLevelTrig),
    .cfgVector    (cfgVector),
    .eoiValid     (eoiValid),
    .eoiVector    (eoiVector),
    .svcReady     (svcReady),
    .strobe       (strobe),
    .svcValid     (svcValid),
    .svcPin       (svcPin),
    .svcVector    (svcVector),
    .svcLevelTrig (svcLevelTrig)
  );

endmodule

// File: rtl/irq_tracker_checker.sv
module irq_tracker_checker #(
  parameter int NumPins = 24,
  parameter int VecW    = 8,
  localparam int PinIdxW = (NumPins > 1) ? $clog2(NumPins) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [NumPins-1:0] cfgLevelTrig,
  input logic [NumPins-1:0] cfgMask,
  input logic               svcReady,
  input logic               svcValid,
  input logic [PinIdxW-1:0] svcPin,
  input logic               svcLevelTrig
);

  assert_masked_never_served_R7: assert property (
    @(posedge clk) disable iff (!rstN)
      svcValid |-> !cfgMask[svcPin]);

  // R5 is covered too: the acknowledge strobe is not excluded here.
  assert_level_hold_off_R3: assert property (
    @(posedge clk) disable iff (!rstN)
      (svcValid && svcReady && svcLevelTrig)
      |=> !(svcValid && svcLevelTrig && svcPin == $past(svcPin)));

  assert_edge_request_held_R6: assert property (
    @(posedge clk) disable iff (!rstN)
      (svcValid && !svcReady && !svcLevelTrig)
      |=> (svcValid || cfgMask != $past(cfgMask) ||
           cfgLevelTrig != $past(cfgLevelTrig)));

  assert_idle_in_reset_R9: assert property (
    @(posedge clk) !rstN |-> (!svcValid && svcPin == '0));

endmodule

bind irq_tracker irq_tracker_checker #(.NumPins(NumPins), .VecW(VecW)) u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .cfgLevelTrig (cfgLevelTrig),
  .cfgMask      (cfgMask),
  .svcReady     (svcReady),
  .svcValid     (svcValid),
  .svcPin       (svcPin),
  .svcLevelTrig (svcLevelTrig)
);

// File: tb/irq_tracker_bench.sv
`timescale 1ns/100ps
module irq_tracker_bench;
  localparam int NumPins = 4;
  localparam int VecW    = 3;
  localparam int PinIdxW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NumPins-1:0] pinLevel = '0;
  logic [NumPins-1:0] cfgPolarity = '0;
  logic [NumPins-1:0] cfgLevelTrig = '0;
  logic [NumPins-1:0] cfgMask = '1;
  logic [VecW-1:0] vec [NumPins];
  logic [NumPins*VecW-1:0] cfgVector;
  logic eoiValid = 1'b0;
  logic [VecW-1:0] eoiVector = '0;
  logic svcReady = 1'b0;
  logic svcValid;
  logic [PinIdxW-1:0] svcPin;
  logic [VecW-1:0] svcVector;
  logic svcLevelTrig;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NumPins; i++) cfgVector[i*VecW +: VecW] = vec[i];
  end

  irq_tracker #(.NumPins(NumPins), .VecW(VecW)) u_irq_tracker (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .cfgPolarity(cfgPolarity),
    .cfgLevelTrig(cfgLevelTrig), .cfgMask(cfgMask), .cfgVector(cfgVector),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .svcReady(svcReady),
    .svcValid(svcValid), .svcPin(svcPin), .svcVector(svcVector),
    .svcLevelTrig(svcLevelTrig)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic grant();
    svcReady = 1'b1;
    step();
    svcReady = 1'b0;
  endtask

  task automatic eoi(int v);
    eoiValid  = 1'b1;
    eoiVector = VecW'(v);
    step();
    eoiValid  = 1'b0;
  endtask

  task automatic quiesce();
    cfgMask  = '1;
    pinLevel = cfgPolarity;
    step();
    step();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NumPins; i++) vec[i] = VecW'(i + 1);
    // R9: state held clear during reset even with active, unmasked level pins
    pinLevel = '1; cfgLevelTrig = '1; cfgMask = '0;
    repeat (3) @(posedge clk);
    #1;
    checkEq("R9 svcValid in reset", svcValid, 0);
    checkEq("R9 svcPin in reset", svcPin, 0);
    pinLevel = '0; cfgMask = '1;
    @(negedge clk);
    rstN = 1'b1;
    step();
    step();
    checkEq("R9 svcValid after reset", svcValid, 0);

    // Sweep: every pin x polarity x trigger mode
    for (int p = 0; p < NumPins; p++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int trig = 0; trig < 2; trig++) begin
          cfgPolarity[p]  = pol[0];
          cfgLevelTrig[p] = trig[0];
          quiesce();
          cfgMask[p] = 1'b0;
          #1;
          checkEq("R1 inactive level gives no request", svcValid, 0);
          pinLevel[p] = ~pol[0];
          step();
          checkEq("R1 active level requests", svcValid, 1);
          checkEq("R8 svcPin", svcPin, p);
          checkEq("R8 svcVector", svcVector, p + 1);
          checkEq("R8 svcLevelTrig", svcLevelTrig, trig);
          grant();
          if (trig == 1) begin
            checkEq("R3 level pin held off after accept", svcValid, 0);
            eoi(7);
            checkEq("R4 non-matching vector keeps hold-off", svcValid, 0);
            eoi(p + 1);
            checkEq("R4 matching vector re-requests", svcValid, 1);
            checkEq("R4 re-request pin", svcPin, p);
            pinLevel[p] = pol[0];
            step();
            checkEq("R2 request withdrawn when level low", svcValid, 0);
          end else begin
            checkEq("R6 steady high does not re-request", svcValid, 0);
            pinLevel[p] = pol[0];
            step();
            pinLevel[p] = ~pol[0];
            step();
            checkEq("R6 new rise latches", svcValid, 1);
            pinLevel[p] = pol[0];
            step();
            checkEq("R6 request held after fall", svcValid, 1);
            grant();
            checkEq("R6 accept clears request", svcValid, 0);
          end
        end
      end
    end

    // R5: accept and matching acknowledge in the same cycle
    cfgPolarity = '0;
    quiesce();
    cfgLevelTrig[0] = 1'b1; vec[0] = 3'd5; cfgMask[0] = 1'b0; pinLevel[0] = 1'b1;
    step();
    checkEq("R5 setup request", svcValid, 1);
    svcReady = 1'b1; eoiValid = 1'b1; eoiVector = 3'd5;
    step();
    svcReady = 1'b0; eoiValid = 1'b0;
    checkEq("R5 accept wins over acknowledge", svcValid, 0);
    eoi(5);
    checkEq("R4 later acknowledge releases", svcValid, 1);
    grant();
    pinLevel[0] = 1'b0;
    eoi(5);
    vec[0] = 3'd1;

    // R7: masking behaviour
    quiesce();
    cfgLevelTrig[1] = 1'b1; pinLevel[1] = 1'b1;
    step();
    step();
    checkEq("R7 masked level pin not served", svcValid, 0);
    cfgMask[1] = 1'b0;
    #1;
    checkEq("R7 unmask presents level pin", svcValid, 1);
    checkEq("R7 unmask pin index", svcPin, 1);
    quiesce();
    cfgLevelTrig[2] = 1'b0; pinLevel[2] = 1'b1;
    step();
    cfgMask[2] = 1'b0;
    #1;
    checkEq("R7 edge seen while masked discarded", svcValid, 0);
    step();
    checkEq("R7 edge still discarded", svcValid, 0);
    pinLevel[2] = 1'b0;
    step();
    pinLevel[2] = 1'b1;
    step();
    checkEq("R7 unmasked edge latches", svcPin, 2);
    cfgMask[2] = 1'b1;
    #1;
    checkEq("R7 latched edge hidden while masked", svcValid, 0);
    cfgMask[2] = 1'b0;
    #1;
    checkEq("R7 latched edge kept across mask", svcValid, 1);
    grant();
    checkEq("R6 accept after unmask clears", svcValid, 0);

    // R8 priority and R4 shared vector release
    quiesce();
    cfgLevelTrig[1] = 1'b1; cfgLevelTrig[3] = 1'b1;
    vec[1] = 3'd6; vec[3] = 3'd6;
    cfgMask[1] = 1'b0; cfgMask[3] = 1'b0;
    pinLevel[1] = 1'b1; pinLevel[3] = 1'b1;
    step();
    checkEq("R8 lowest pin first", svcPin, 1);
    grant();
    checkEq("R8 next pin after accept", svcPin, 3);
    checkEq("R8 next pin valid", svcValid, 1);
    grant();
    checkEq("R3 both pins held off", svcValid, 0);
    eoi(6);
    checkEq("R4 shared vector releases lowest", svcPin, 1);
    grant();
    checkEq("R4 shared vector released second pin", svcPin, 3);
    checkEq("R4 second pin valid", svcValid, 1);
    grant();
    pinLevel = '0;
    eoi(6);
    step();
    checkEq("R2 idle at end", svcValid, 0);
    checkEq("R8 svcPin zero when idle", svcPin, 0);

    finishRun();
  end
endmodule